// File: doc/BRIEF.md
# Next-PC and Micro-PC Sequencer

This block works out where fetch goes after each instruction. The program counter state has three parts. The first is the address of the current instruction. The second is the address that follows it. The third is a micro-step index inside a macro-instruction.

For each instruction it receives the current state and three class flags: control transfer, micro-op, and final micro-op. It also receives the predictor's verdict and target. From these it returns the successor state, a predicted-taken flag and a flag that closes the current fetch group. Fetch attaches the returned state to the instruction as its prediction. The branch predictor and the instruction decoder sit outside the block.

A mode pin selects one of two architectures. In the first, a branch takes effect one instruction late, after a delay slot. In the second, it takes effect at once.

Instructions enter and results leave on valid/ready streams, with one register stage between them. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the output on the following cycle. A result stays on the output, unchanged, until `out_ready` is seen high with `out_valid`. While a result is held there, `in_ready` is low. When the output is empty or is being drained in the same cycle, `in_ready` is high, so one instruction per cycle can flow.

The mode pin is sampled on the cycle the input is accepted. It should be kept steady while instructions are in flight.

Top module: `npc_seq`

## Requirements
- R1: A non-control micro-op that is not the final micro-op (in_is_ctrl=0, in_is_uop=1, in_is_last_uop=0) yields out_pc = in_pc and out_npc = in_npc. It yields out_upc = in_upc + 1, modulo 2^UPC_W.
- R2: Any other non-control instruction yields out_pc = in_npc, out_npc = in_npc + INST_BYTES and out_upc = 0.
- R3: A non-control instruction yields out_taken = 0 and out_end_group = 0.
- R4: A control instruction (in_is_ctrl=1) always yields out_upc = 0.
- R5: With delay_slot_mode=1, a control instruction yields out_pc = in_npc. It yields out_npc = bp_target when bp_taken=1, and in_npc + INST_BYTES otherwise.
- R6: With delay_slot_mode=0, a control instruction yields out_pc = bp_target when bp_taken=1, and in_pc + INST_BYTES otherwise. In both cases out_npc = out_pc + INST_BYTES.
- R7: A control instruction yields out_taken = bp_taken and out_end_group = bp_taken.
- R8: After reset out_valid is 0. An accepted input produces out_valid = 1 with its result on the next cycle.
- R9: While out_valid=1 and out_ready=0, all outputs hold and in_ready is 0. Otherwise in_ready is 1.
- R10: When in_is_ctrl=1, the micro-op flags have no effect: the control rules R4 to R7 apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_slot_mode | input | 1 | 1 selects delayed branches, 0 selects immediate branches |
| in_valid | input | 1 | Input instruction present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_pc | input | 32 | Current instruction address |
| in_npc | input | 32 | Address following the current one |
| in_upc | input | UPC_W | Current micro-step index |
| in_is_ctrl | input | 1 | Instruction is a control transfer |
| in_is_uop | input | 1 | Instruction is a micro-op |
| in_is_last_uop | input | 1 | Micro-op is the final one of its macro-op |
| bp_taken | input | 1 | Predictor says taken |
| bp_target | input | 32 | Predicted target address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_pc | output | 32 | Successor instruction address |
| out_npc | output | 32 | Address after the successor |
| out_upc | output | UPC_W | Successor micro-step index |
| out_taken | output | 1 | Predicted-taken flag for the instruction |
| out_end_group | output | 1 | Close the current fetch group |

## Verification
Two functions can fall on the same cycle in this block.

The first pair is the micro-op stepping rule and the control rule. Both apply when one instruction has in_is_ctrl and in_is_uop set and in_is_last_uop clear. The bench drives this combination in both modes and judges the result against the control rules, expecting a cleared micro-step index.

The second pair is output back-pressure and a new input. They coincide when out_ready is dropped while in_valid stays high. The bench's reference model requires the held result to be unchanged, in_ready to be low, and the waiting input to be taken on the first cycle the output drains.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_W = 32;
  localparam int UPC_W  = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] npc;
    logic [UPC_W-1:0]  upc;
  } pc_triple_t;
endpackage

// File: rtl/npc_flow_step.sv
module npc_flow_step
  import npc_pkg::*;
#(
  parameter int INST_BYTES = 4
) (
  input  pc_triple_t cur,
  input  logic       is_uop,
  input  logic       is_last_uop,
  output pc_triple_t nxt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  always_comb begin
    if (is_uop && !is_last_uop) begin
      // stay inside the macro-op: only the micro index moves
      nxt.pc  = cur.pc;
      nxt.npc = cur.npc;
      nxt.upc = cur.upc + 1'b1;
    end else begin
      nxt.pc  = cur.npc;
      nxt.npc = cur.npc + STEP;
      nxt.upc = '0;
    end
  end
endmodule

// File: rtl/npc_branch_step.sv
module npc_branch_step
  import npc_pkg::*;
#(
  parameter int INST_BYTES = 4
) (
  input  pc_triple_t        cur,
  input  logic              ds_mode,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  output pc_triple_t        nxt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [ADDR_W-1:0] imm_pc;

  assign imm_pc = taken ? target : (cur.pc + STEP);

  always_comb begin
    if (ds_mode) begin
      // the slot instruction runs first, the target follows it
      nxt.pc  = cur.npc;
      nxt.npc = taken ? target : (cur.npc + STEP);
    end else begin
      nxt.pc  = imm_pc;
      nxt.npc = imm_pc + STEP;
    end
    nxt.upc = '0;
  end
endmodule

// File: rtl/npc_out_reg.sv
module npc_out_reg
  import npc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  pc_triple_t d_trip,
  input  logic       d_taken,
  output logic       q_valid,
  input  logic       q_ready,
  output pc_triple_t q_trip,
  output logic       q_taken
);
  logic load;

  assign in_ready = !q_valid || q_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_trip  <= '0;
      q_taken <= 1'b0;
    end else begin
      if (in_ready) q_valid <= in_valid;
      if (load) begin
        q_trip  <= d_trip;
        q_taken <= d_taken;
      end
    end
  end
endmodule

// File: rtl/npc_seq.sv
module npc_seq
  import npc_pkg::*;
#(
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              delay_slot_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_npc,
  input  logic [UPC_W-1:0]  in_upc,
  input  logic              in_is_ctrl,
  input  logic              in_is_uop,
  input  logic              in_is_last_uop,
  input  logic              bp_taken,
  input  logic [ADDR_W-1:0] bp_target,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_pc,
  output logic [ADDR_W-1:0] out_npc,
  output logic [UPC_W-1:0]  out_upc,
  output logic              out_taken,
  output logic              out_end_group
);
  pc_triple_t cur_t, flow_t, br_t, sel_t, q_t;
  logic       sel_taken;

  assign cur_t = '{pc: in_pc, npc: in_npc, upc: in_upc};

  npc_flow_step #(.INST_BYTES(INST_BYTES)) u_flow (
    .cur(cur_t), .is_uop(in_is_uop), .is_last_uop(in_is_last_uop), .nxt(flow_t)
  );

  npc_branch_step #(.INST_BYTES(INST_BYTES)) u_br (
    .cur(cur_t), .ds_mode(delay_slot_mode), .taken(bp_taken),
    .target(bp_target), .nxt(br_t)
  );

  // control class takes priority over micro-op flags
  assign sel_t     = in_is_ctrl ? br_t : flow_t;
  assign sel_taken = in_is_ctrl && bp_taken;

  npc_out_reg u_oreg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_trip(sel_t), .d_taken(sel_taken), .q_valid(out_valid),
    .q_ready(out_ready), .q_trip(q_t), .q_taken(out_taken)
  );

  assign out_pc        = q_t.pc;
  assign out_npc       = q_t.npc;
  assign out_upc       = q_t.upc;
  assign out_end_group = out_taken;
endmodule

// File: rtl/npc_seq_chk.sv
module npc_seq_chk
  import npc_pkg::*;
#(
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              delay_slot_mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_pc,
  input logic [ADDR_W-1:0] in_npc,
  input logic [UPC_W-1:0]  in_upc,
  input logic              in_is_ctrl,
  input logic              in_is_uop,
  input logic              in_is_last_uop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_pc,
  input logic [ADDR_W-1:0] out_npc,
  input logic [UPC_W-1:0]  out_upc,
  input logic              out_taken,
  input logic              out_end_group
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_UOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_is_ctrl && in_is_uop && !in_is_last_uop |=>
      out_pc == $past(in_pc) && out_npc == $past(in_npc) &&
      out_upc == UPC_W'($past(in_upc) + 1'b1)); // R1
  AST_NONCTRL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_is_ctrl |=> out_valid && !out_taken && !out_end_group); // R3
  AST_CTRL_UPC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_is_ctrl |=> out_upc == '0); // R4
  AST_DS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_is_ctrl && delay_slot_mode |=> out_pc == $past(in_npc)); // R5
  AST_IMM_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_is_ctrl && !delay_slot_mode |=>
      out_npc == out_pc + ADDR_W'(INST_BYTES)); // R6
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) &&
      $stable(out_npc) && $stable(out_upc) && $stable(out_taken)); // R9
  AST_STALL_NOREADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

bind npc_seq npc_seq_chk #(.INST_BYTES(INST_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .delay_slot_mode(delay_slot_mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc), .in_npc(in_npc),
  .in_upc(in_upc), .in_is_ctrl(in_is_ctrl), .in_is_uop(in_is_uop),
  .in_is_last_uop(in_is_last_uop), .out_valid(out_valid),
  .out_ready(out_ready), .out_pc(out_pc), .out_npc(out_npc),
  .out_upc(out_upc), .out_taken(out_taken), .out_end_group(out_end_group)
);

// File: tb/npc_seq_tb.sv
module npc_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ISZ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ds = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0, in_npc = '0, bp_target = '0;
  logic [7:0]  in_upc = '0;
  logic        is_ctrl = 1'b0, is_uop = 1'b0, is_last = 1'b0, bp_taken = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_pc, out_npc;
  logic [7:0]  out_upc;
  logic        out_taken, out_end;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_valid = 0;
  logic [31:0] m_pc = '0, m_npc = '0;
  logic [7:0]  m_upc = '0;
  bit          m_taken = 0;
  string       m_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_seq #(.INST_BYTES(ISZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .delay_slot_mode(ds), .in_valid(in_valid),
    .in_ready(in_ready), .in_pc(in_pc), .in_npc(in_npc), .in_upc(in_upc),
    .in_is_ctrl(is_ctrl), .in_is_uop(is_uop), .in_is_last_uop(is_last),
    .bp_taken(bp_taken), .bp_target(bp_target), .out_valid(out_valid),
    .out_ready(out_ready), .out_pc(out_pc), .out_npc(out_npc),
    .out_upc(out_upc), .out_taken(out_taken), .out_end_group(out_end)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_tag = "R8";
    end else begin
      if (m_valid && !out_ready) m_tag = "R9";
      else begin
        m_valid = in_valid;
        if (in_valid) begin
          m_taken = 0;
          if (is_ctrl) begin
            m_upc = 0; m_taken = bp_taken;
            if (ds) begin
              m_tag = (is_uop && !is_last) ? "R10" : "R5";
              m_pc = in_npc;
              m_npc = bp_taken ? bp_target : in_npc + ISZ;
            end else begin
              m_tag = (is_uop && !is_last) ? "R10" : "R6";
              m_pc = bp_taken ? bp_target : in_pc + ISZ;
              m_npc = m_pc + ISZ;
            end
          end else if (is_uop && !is_last) begin
            m_tag = "R1"; m_pc = in_pc; m_npc = in_npc; m_upc = in_upc + 8'd1;
          end else begin
            m_tag = "R2"; m_pc = in_npc; m_npc = in_npc + ISZ; m_upc = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!done) begin
      chk("R9", "in_ready", in_ready, !m_valid || out_ready);
      chk("R8", "out_valid", out_valid, m_valid);
      if (m_valid && rst_n) begin
        chk(m_tag, "out_pc", out_pc, m_pc);
        chk(m_tag, "out_npc", out_npc, m_npc);
        chk(m_tag == "R6" || m_tag == "R5" ? "R4" : m_tag, "out_upc", out_upc, m_upc);
        chk(m_taken ? "R7" : "R3", "out_taken", out_taken, m_taken);
        chk(m_taken ? "R7" : "R3", "out_end_group", out_end, m_taken);
      end
    end
  end

  task automatic put(bit c, bit u, bit l, bit t, logic [31:0] pc,
                     logic [31:0] npc, logic [7:0] up, logic [31:0] tgt);
    @(negedge clk); #1;
    in_valid = 1; is_ctrl = c; is_uop = u; is_last = l; bp_taken = t;
    in_pc = pc; in_npc = npc; in_upc = up; bp_target = tgt;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 step and wrap of micro index, R2 sequential, R3 no-taken
    put(0, 1, 0, 0, 32'h100, 32'h104, 8'd3, 32'h0);
    put(0, 1, 0, 1, 32'h100, 32'h104, 8'hFF, 32'h900);
    put(0, 1, 1, 1, 32'h100, 32'h104, 8'd7, 32'h900);
    put(0, 0, 0, 0, 32'h200, 32'h300, 8'd2, 32'h0);
    // R6 immediate mode taken/not taken, R10 ctrl with uop flags
    ds = 0;
    put(1, 0, 0, 1, 32'h400, 32'h404, 8'd5, 32'h800);
    put(1, 0, 0, 0, 32'h400, 32'h404, 8'd5, 32'h800);
    put(1, 1, 0, 1, 32'h500, 32'h504, 8'd9, 32'hA00);
    // R5 delayed mode
    @(negedge clk); #1 in_valid = 0; ds = 1;
    put(1, 0, 0, 1, 32'h600, 32'h604, 8'd1, 32'hC00);
    put(1, 0, 0, 0, 32'h600, 32'h604, 8'd1, 32'hC00);
    put(1, 1, 0, 0, 32'h700, 32'h704, 8'd4, 32'hC00);
    // R9 back-pressure while input waits
    @(negedge clk); #1 out_ready = 0;
    put(0, 0, 0, 0, 32'h10, 32'h20, 8'd0, 32'h0);
    repeat (3) @(negedge clk);
    #1 out_ready = 1;
    @(negedge clk); #1 in_valid = 0;
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (i % 50 == 0) begin in_valid = 0; @(negedge clk); #1 ds = $urandom_range(0, 1); end
      in_valid = $urandom_range(0, 3) != 0;
      out_ready = $urandom_range(0, 3) != 0;
      is_ctrl = $urandom_range(0, 1); is_uop = $urandom_range(0, 1);
      is_last = $urandom_range(0, 1); bp_taken = $urandom_range(0, 1);
      in_pc = $urandom; in_npc = $urandom; in_upc = $urandom; bp_target = $urandom;
    end
    @(negedge clk); #1 in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule